// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Register

This block is the digital front end of a 256-step resistor ladder. It is a write-only serial slave with three wires: an active-low select, a serial clock and a serial data line. While select is held low, each rising edge of the serial clock pushes the data bit into an input register, most significant bit first. When select returns high, the input register is copied into the wiper register. The wiper register drives a parallel code to a downstream tap decoder. Code 0x00 puts the wiper at the bottom end of the ladder, and 0xFF puts it one step below the top.

The serial clock, select and data lines are not timed by the system clock. Each one passes through its own two-flop synchronizer into a faster system clock. Edges are found by comparing the current synchronized sample with the previous one. Each time the wiper register is loaded, a one-cycle strobe is raised in the system clock domain. After reset the wiper sits at midscale, so the ladder starts in a safe middle position before any software writes it.

Top module: `serial_wiper_reg`

## Requirements
- R1: While reset is asserted and after it is released, `wiperCode` equals 0x80 (midscale) and `updated` is 0 until the first load.
- R2: With `selN` low, each rising edge of `sclk` samples `sdi`. Bits enter most significant first. When `selN` rises, the 8-bit word is copied to `wiperCode` within 4 system clocks.
- R3: If more than 8 rising edges of `sclk` occur in one select-low period, only the last 8 bits received are kept. Earlier bits are discarded.
- R4: If fewer than 8 bits arrive, the partial value is still committed. The bits received occupy the low positions, oldest bit highest, and every position that received no bit reads 0.
- R5: `updated` is high for exactly one system clock per load. It rises in the same cycle that `wiperCode` takes the new value.
- R6: While `selN` is high, activity on `sclk` and `sdi` changes neither `wiperCode` nor `updated`.
- R7: The input register is cleared when `selN` falls. A select-low period with no `sclk` edges commits 0x00.
- R8: The full code range is supported: both 0x00 and 0xFF can be loaded and then read back on `wiperCode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| wiperCode | output | 8 | Current wiper tap code |
| updated | output | 1 | One-cycle pulse when the wiper register is loaded |

## Verification
The bench sends exact 8-bit words with alternating, all-ones and all-zeros patterns. These show whether bit order and the sampling edge are right. Long words of 12 bits tell keep-the-last-eight apart from keep-the-first-eight. Short words of 3 bits and empty transactions show whether the register is cleared when select falls and where partial bits land. A burst of clock and data toggles with select high shows whether activity while idle leaks into the wiper. Every clock is also compared against a behavioural model, which places each load and strobe in the exact cycle it should occur.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Strobes from the control path to the datapath, one system clock wide.
  typedef struct packed {
    logic clear;   // select just fell: empty the input register
    logic shift;   // serial clock rose while selected: take one bit
    logic commit;  // select just rose: copy input register to wiper
  } wiperStrb_t;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       sclk,
  input  logic       sdi,
  output wiperStrb_t strb,
  output logic       sdiBit
);

  logic selS, sclkS, sdiS;
  logic selPrev, sclkPrev;

  // Select idles high, clock idles low.
  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_selSync (
    .clk(clk), .rstN(rstN), .din(selN), .dout(selS)
  );
  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclkSync (
    .clk(clk), .rstN(rstN), .din(sclk), .dout(sclkS)
  );
  // Data goes through the same depth so it stays aligned with the clock edge.
  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdiSync (
    .clk(clk), .rstN(rstN), .din(sdi), .dout(sdiS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      selPrev  <= selS;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    strb.clear  = selPrev & ~selS;
    strb.commit = ~selPrev & selS;
    strb.shift  = ~selS & sclkS & ~sclkPrev;
  end

  assign sdiBit = sdiS;

  // R6: no bit is taken while the synchronized select is inactive.
  a_r6_no_shift_idle: assert property (@(posedge clk) disable iff (!rstN)
    selS |-> !strb.shift);

  // R2: a load and a shift never happen in the same cycle.
  a_r2_commit_alone: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shift, strb.commit}));

endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int                CODE_W     = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  wiperStrb_t        strb,
  input  logic              sdiBit,
  output logic [CODE_W-1:0] wiperCode,
  output logic              updated
);

  logic [CODE_W-1:0] shiftQ;
  logic [CODE_W-1:0] wiperQ;
  logic              updQ;

  // Input register: new bit enters at the LSB, oldest bits fall off the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftQ <= '0;
    else if (strb.clear)  shiftQ <= '0;
    else if (strb.shift)  shiftQ <= {shiftQ[CODE_W-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperQ <= RESET_CODE;
      updQ   <= 1'b0;
    end else begin
      updQ <= strb.commit;
      if (strb.commit) wiperQ <= shiftQ;
    end
  end

  assign wiperCode = wiperQ;
  assign updated   = updQ;

  // R6: the wiper moves only on a load.
  a_r6_wiper_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(wiperQ));

  // R5: a load raises the strobe together with the new code.
  a_r5_pulse_marks_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (updQ && wiperQ == $past(shiftQ)));

  // R5: the strobe lasts one cycle only.
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updQ |=> !updQ);

  // R7: select falling leaves the input register empty.
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && !strb.shift) |=> shiftQ == '0);

endmodule

// File: rtl/serial_wiper_reg.sv
module serial_wiper_reg
  import wiper_pkg::*;
#(
  parameter int                CODE_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE  = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] wiperCode,
  output logic              updated
);

  wiperStrb_t strb;
  logic       sdiBit;

  wiper_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .strb(strb), .sdiBit(sdiBit)
  );

  wiper_datapath #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiBit(sdiBit),
    .wiperCode(wiperCode), .updated(updated)
  );

  // R1: midscale is the power-on value.
  a_r1_midscale_reset: assert property (@(posedge clk)
    !rstN |=> (wiperCode == RESET_CODE && !updated));

endmodule

// File: tb/serial_wiper_reg_tb.sv
`timescale 1ns/1ps
module serial_wiper_reg_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic sclk = 1'b0;
  logic sdi  = 1'b0;
  logic [7:0] wiperCode;
  logic       updated;

  int checks = 0;
  int failures = 0;
  int updCount = 0;
  bit done = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  serial_wiper_reg dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .wiperCode(wiperCode), .updated(updated)
  );

  // Behavioural reference: input history sampled at each edge, integer state.
  logic [3:0] selH, clkH, datH;
  int  mShift, mWiper;
  bit  mUpd;

  always @(posedge clk) begin
    if (!rstN) begin
      selH = 4'hF; clkH = 4'h0; datH = 4'h0;
      mShift = 0; mWiper = 128; mUpd = 0;
    end else begin
      selH = {selH[2:0], selN};
      clkH = {clkH[2:0], sclk};
      datH = {datH[2:0], sdi};
      mUpd = 0;
      if (selH[3] && !selH[2]) mShift = 0;
      else if (!selH[2] && clkH[2] && !clkH[3])
        mShift = (mShift * 2 + int'(datH[2])) % 256;
      if (!selH[3] && selH[2]) begin
        mWiper = mShift;
        mUpd = 1;
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  // Every-clock comparison against the model, plus strobe counting.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " per-cycle code"}, int'(wiperCode), mWiper);
      check({curReq, " per-cycle strobe"}, int'(updated), int'(mUpd));
      if (updated) updCount++;
    end
  end

  task automatic xfer(input int n, input logic [31:0] val);
    selN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = val[i];
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    selN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Expected code from the requirements: last min(n,8) bits, right-aligned.
  function automatic int expCode(input int n, input logic [31:0] val);
    longint m;
    m = (n >= 8) ? 64'hFF : ((64'd1 << n) - 1);
    return int'(longint'(val) & m);
  endfunction

  task automatic load(input string req, input int n, input logic [31:0] val);
    curReq = req;
    updCount = 0;
    xfer(n, val);
    check({req, " code"}, int'(wiperCode), expCode(n, val));
    check("R5 one strobe per load", updCount, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(wiperCode), 8'h80);
    check("R1 reset strobe", int'(updated), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 code after release", int'(wiperCode), 8'h80);

    load("R2", 8, 32'hA5);
    load("R2", 8, 32'h3C);
    load("R8", 8, 32'hFF);
    load("R8", 8, 32'h00);
    load("R3", 12, 32'hB6E);     // last eight bits 0x6E
    load("R3", 9, 32'h1C3);      // last eight bits 0xC3
    load("R4", 3, 32'h5);        // 0x05
    load("R4", 1, 32'h1);        // 0x01
    load("R2", 8, 32'h81);

    // R7: empty select period commits zero.
    load("R7", 0, 32'h0);
    load("R2", 8, 32'h5A);

    // R6: activity while deselected is ignored.
    curReq = "R6";
    updCount = 0;
    for (int k = 0; k < 20; k++) begin
      sdi = k[0];
      repeat (2) @(negedge clk);
      sclk = ~sclk;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 code unchanged", int'(wiperCode), 8'h5A);
    check("R6 no strobe", updCount, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired got=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule